// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal and vertical sync, data-enable and field signals for a display output, together with the running pixel and line positions. Software sets the raster geometry through plain register inputs: the frame size, where the visible window sits on each axis, the width of each sync pulse and three control bits. The control bits pick the sync polarities and turn interlace on or off.

Both position counters start from zero at the leading edge of sync. The visible window is therefore described by offsets from sync, not by offsets from the start of active video. In interlaced operation the second field has its own line count and its own vertical window. Register values are captured in a shadow bank only at a field boundary, so one frame never runs with a mix of old and new settings.

Top module: `raster_gen`

## Requirements
- R1: While `rst_n` is low, `hsync`, `vsync`, `de`, `field`, `h_pos` and `v_pos` are all 0. The shadow bank resets to zero, which makes the first clock after reset a field boundary, and that boundary captures the register inputs.
- R2: `h_pos` counts up by one each clock from 0 to the captured `cfg_h_last` (the total pixel count minus one) and then returns to 0.
- R3: `v_pos` advances by one in each clock where `h_pos` wraps. In field 0 it returns to 0 after the line equal to `cfg_v_last` (the total line count minus one). In field 1 it returns to 0 after the line equal to `cfg_v2_total`.
- R4: The internal horizontal pulse is high while `h_pos < cfg_hs_width`. `hsync` equals this pulse when `cfg_ctrl` bit 0 is 0 and its inverse when bit 0 is 1 (active-low).
- R5: The internal vertical pulse is high while `v_pos < cfg_vs_width`. `vsync` equals this pulse when `cfg_ctrl` bit 1 is 0 and its inverse when bit 1 is 1.
- R6: `de` is high exactly when `cfg_h_act_beg <= h_pos < cfg_h_act_end` and the line lies in the vertical window of the current field. For field 0 that window is `cfg_v_act_beg <= v_pos < cfg_v_act_end`. For field 1 it is `cfg_v2_act_beg <= v_pos < cfg_v2_act_end`. Each window includes its start and excludes its end.
- R7: The register inputs are captured only at a field boundary, which is the clock where both counters wrap together. A change at any other time has no effect on the outputs until the next boundary.
- R8: At each field boundary, `field` toggles if the values being captured have `cfg_ctrl` bit 2 set and a nonzero `cfg_v2_total`. Otherwise `field` goes to 0 at that boundary.
- R9: With `cfg_ctrl` bit 2 clear, `field` stays 0. The second-field total and window inputs then have no effect, even when they are nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_h_last | input | HW | Pixels per line minus one |
| cfg_v_last | input | VW | Lines in field 0 minus one |
| cfg_h_act_beg | input | HW | First active pixel, counted from sync start |
| cfg_h_act_end | input | HW | First pixel after the active span |
| cfg_v_act_beg | input | VW | First active line of field 0 |
| cfg_v_act_end | input | VW | First line after field 0's active span |
| cfg_v2_total | input | VW | Last line index of field 1; 0 in progressive use |
| cfg_v2_act_beg | input | VW | First active line of field 1 |
| cfg_v2_act_end | input | VW | First line after field 1's active span |
| cfg_hs_width | input | HW | Horizontal sync width in pixels |
| cfg_vs_width | input | VW | Vertical sync width in lines |
| cfg_ctrl | input | 3 | Bit 0 active-low hsync, bit 1 active-low vsync, bit 2 interlace |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| field | output | 1 | Current field, 1 means second field |
| h_pos | output | HW | Current pixel position |
| v_pos | output | VW | Current line position |

## Verification
A corrupted position counter shows up on `h_pos` or `v_pos` in the very next cycle. It then moves the sync and data-enable edges for the rest of the frame. A shadow bank that captures at the wrong moment becomes visible within one line: the counter wraps at a total that the current frame should not yet be using. A wrong field decision shows on `field` and in `de`'s vertical window from the first line of the following field. It also changes when the next wrap occurs, roughly one field later.

// File: rtl/raster_gen_pkg.sv
package raster_gen_pkg;

    localparam int CTL_W      = 3;
    localparam int CTL_HS_LOW = 0;
    localparam int CTL_VS_LOW = 1;
    localparam int CTL_ILACE  = 2;

    // Half-open span test: start inclusive, end exclusive.
    function automatic logic in_span(input int unsigned pos,
                                     input int unsigned beg,
                                     input int unsigned fin);
        return (pos >= beg) && (pos < fin);
    endfunction

endpackage

// File: rtl/raster_shadow.sv
module raster_shadow
    import raster_gen_pkg::*;
#(
    parameter int HW = 12,
    parameter int VW = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [HW-1:0]    in_h_last,
    input  logic [VW-1:0]    in_v_last,
    input  logic [HW-1:0]    in_h_beg,
    input  logic [HW-1:0]    in_h_end,
    input  logic [VW-1:0]    in_v_beg,
    input  logic [VW-1:0]    in_v_end,
    input  logic [VW-1:0]    in_v2_total,
    input  logic [VW-1:0]    in_v2_beg,
    input  logic [VW-1:0]    in_v2_end,
    input  logic [HW-1:0]    in_hs_w,
    input  logic [VW-1:0]    in_vs_w,
    input  logic [CTL_W-1:0] in_ctrl,
    output logic [HW-1:0]    sh_h_last,
    output logic [VW-1:0]    sh_v_last,
    output logic [HW-1:0]    sh_h_beg,
    output logic [HW-1:0]    sh_h_end,
    output logic [VW-1:0]    sh_v_beg,
    output logic [VW-1:0]    sh_v_end,
    output logic [VW-1:0]    sh_v2_total,
    output logic [VW-1:0]    sh_v2_beg,
    output logic [VW-1:0]    sh_v2_end,
    output logic [HW-1:0]    sh_hs_w,
    output logic [VW-1:0]    sh_vs_w,
    output logic [CTL_W-1:0] sh_ctrl
);

    typedef struct packed {
        logic [HW-1:0]    h_last;
        logic [VW-1:0]    v_last;
        logic [HW-1:0]    h_beg;
        logic [HW-1:0]    h_end;
        logic [VW-1:0]    v_beg;
        logic [VW-1:0]    v_end;
        logic [VW-1:0]    v2_total;
        logic [VW-1:0]    v2_beg;
        logic [VW-1:0]    v2_end;
        logic [HW-1:0]    hs_w;
        logic [VW-1:0]    vs_w;
        logic [CTL_W-1:0] ctrl;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (load) begin
            bank_d = '{h_last:   in_h_last,
                       v_last:   in_v_last,
                       h_beg:    in_h_beg,
                       h_end:    in_h_end,
                       v_beg:    in_v_beg,
                       v_end:    in_v_end,
                       v2_total: in_v2_total,
                       v2_beg:   in_v2_beg,
                       v2_end:   in_v2_end,
                       hs_w:     in_hs_w,
                       vs_w:     in_vs_w,
                       ctrl:     in_ctrl};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign sh_h_last   = bank_q.h_last;
    assign sh_v_last   = bank_q.v_last;
    assign sh_h_beg    = bank_q.h_beg;
    assign sh_h_end    = bank_q.h_end;
    assign sh_v_beg    = bank_q.v_beg;
    assign sh_v_end    = bank_q.v_end;
    assign sh_v2_total = bank_q.v2_total;
    assign sh_v2_beg   = bank_q.v2_beg;
    assign sh_v2_end   = bank_q.v2_end;
    assign sh_hs_w     = bank_q.hs_w;
    assign sh_vs_w     = bank_q.vs_w;
    assign sh_ctrl     = bank_q.ctrl;

endmodule

// File: rtl/raster_counter.sv
module raster_counter #(
    parameter int HW = 12,
    parameter int VW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [HW-1:0] lim_h,
    input  logic [VW-1:0] lim_v_f0,
    input  logic [VW-1:0] lim_v_f1,
    input  logic          next_ilace,
    output logic [HW-1:0] h_cnt,
    output logic [VW-1:0] v_cnt,
    output logic          fld,
    output logic          boundary
);

    typedef struct packed {
        logic [HW-1:0] h;
        logic [VW-1:0] v;
        logic          f;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic line_end;
    logic last_line;

    always_comb begin
        line_end  = (cnt_q.h == lim_h);
        last_line = cnt_q.f ? (cnt_q.v == lim_v_f1) : (cnt_q.v == lim_v_f0);
        boundary  = line_end && last_line;

        cnt_d = cnt_q;
        if (line_end) begin
            cnt_d.h = '0;
            if (last_line) begin
                cnt_d.v = '0;
                cnt_d.f = next_ilace ? ~cnt_q.f : 1'b0;
            end else begin
                cnt_d.v = cnt_q.v + 1'b1;
            end
        end else begin
            cnt_d.h = cnt_q.h + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign h_cnt = cnt_q.h;
    assign v_cnt = cnt_q.v;
    assign fld   = cnt_q.f;

endmodule

// File: rtl/raster_pulse.sv
module raster_pulse #(
    parameter int W = 12
) (
    input  logic [W-1:0] pos,
    input  logic [W-1:0] width,
    input  logic         invert,
    output logic         pulse
);

    logic raw;

    always_comb begin
        raw   = (pos < width);
        pulse = raw ^ invert;
    end

endmodule

// File: rtl/raster_decode.sv
module raster_decode
    import raster_gen_pkg::*;
#(
    parameter int HW = 12,
    parameter int VW = 11
) (
    input  logic [HW-1:0]    h,
    input  logic [VW-1:0]    v,
    input  logic             fld,
    input  logic [HW-1:0]    h_beg,
    input  logic [HW-1:0]    h_end,
    input  logic [VW-1:0]    v_beg,
    input  logic [VW-1:0]    v_end,
    input  logic [VW-1:0]    v2_beg,
    input  logic [VW-1:0]    v2_end,
    input  logic [HW-1:0]    hs_w,
    input  logic [VW-1:0]    vs_w,
    input  logic [CTL_W-1:0] ctrl,
    output logic             hs,
    output logic             vs,
    output logic             act
);

    logic          h_in;
    logic          v_in;
    logic [VW-1:0] win_beg;
    logic [VW-1:0] win_end;

    raster_pulse #(.W(HW)) u_hpulse (
        .pos    (h),
        .width  (hs_w),
        .invert (ctrl[CTL_HS_LOW]),
        .pulse  (hs)
    );

    raster_pulse #(.W(VW)) u_vpulse (
        .pos    (v),
        .width  (vs_w),
        .invert (ctrl[CTL_VS_LOW]),
        .pulse  (vs)
    );

    always_comb begin
        win_beg = fld ? v2_beg : v_beg;
        win_end = fld ? v2_end : v_end;
        h_in    = in_span(32'(h), 32'(h_beg), 32'(h_end));
        v_in    = in_span(32'(v), 32'(win_beg), 32'(win_end));
        act     = h_in && v_in;
    end

endmodule

// File: rtl/raster_gen.sv
module raster_gen
    import raster_gen_pkg::*;
#(
    parameter int HW = 12,
    parameter int VW = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [HW-1:0]    cfg_h_last,
    input  logic [VW-1:0]    cfg_v_last,
    input  logic [HW-1:0]    cfg_h_act_beg,
    input  logic [HW-1:0]    cfg_h_act_end,
    input  logic [VW-1:0]    cfg_v_act_beg,
    input  logic [VW-1:0]    cfg_v_act_end,
    input  logic [VW-1:0]    cfg_v2_total,
    input  logic [VW-1:0]    cfg_v2_act_beg,
    input  logic [VW-1:0]    cfg_v2_act_end,
    input  logic [HW-1:0]    cfg_hs_width,
    input  logic [VW-1:0]    cfg_vs_width,
    input  logic [CTL_W-1:0] cfg_ctrl,
    output logic             hsync,
    output logic             vsync,
    output logic             de,
    output logic             field,
    output logic [HW-1:0]    h_pos,
    output logic [VW-1:0]    v_pos
);

    logic [HW-1:0]    sh_h_last;
    logic [VW-1:0]    sh_v_last;
    logic [HW-1:0]    sh_h_beg;
    logic [HW-1:0]    sh_h_end;
    logic [VW-1:0]    sh_v_beg;
    logic [VW-1:0]    sh_v_end;
    logic [VW-1:0]    sh_v2_total;
    logic [VW-1:0]    sh_v2_beg;
    logic [VW-1:0]    sh_v2_end;
    logic [HW-1:0]    sh_hs_w;
    logic [VW-1:0]    sh_vs_w;
    logic [CTL_W-1:0] sh_ctrl;
    logic             at_boundary;
    logic             ilace_req;

    // Decided from the values being captured, so field and bank agree.
    assign ilace_req = cfg_ctrl[CTL_ILACE] && (cfg_v2_total != '0);

    raster_shadow #(.HW(HW), .VW(VW)) u_shadow (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (at_boundary),
        .in_h_last   (cfg_h_last),
        .in_v_last   (cfg_v_last),
        .in_h_beg    (cfg_h_act_beg),
        .in_h_end    (cfg_h_act_end),
        .in_v_beg    (cfg_v_act_beg),
        .in_v_end    (cfg_v_act_end),
        .in_v2_total (cfg_v2_total),
        .in_v2_beg   (cfg_v2_act_beg),
        .in_v2_end   (cfg_v2_act_end),
        .in_hs_w     (cfg_hs_width),
        .in_vs_w     (cfg_vs_width),
        .in_ctrl     (cfg_ctrl),
        .sh_h_last   (sh_h_last),
        .sh_v_last   (sh_v_last),
        .sh_h_beg    (sh_h_beg),
        .sh_h_end    (sh_h_end),
        .sh_v_beg    (sh_v_beg),
        .sh_v_end    (sh_v_end),
        .sh_v2_total (sh_v2_total),
        .sh_v2_beg   (sh_v2_beg),
        .sh_v2_end   (sh_v2_end),
        .sh_hs_w     (sh_hs_w),
        .sh_vs_w     (sh_vs_w),
        .sh_ctrl     (sh_ctrl)
    );

    raster_counter #(.HW(HW), .VW(VW)) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .lim_h      (sh_h_last),
        .lim_v_f0   (sh_v_last),
        .lim_v_f1   (sh_v2_total),
        .next_ilace (ilace_req),
        .h_cnt      (h_pos),
        .v_cnt      (v_pos),
        .fld        (field),
        .boundary   (at_boundary)
    );

    raster_decode #(.HW(HW), .VW(VW)) u_decode (
        .h      (h_pos),
        .v      (v_pos),
        .fld    (field),
        .h_beg  (sh_h_beg),
        .h_end  (sh_h_end),
        .v_beg  (sh_v_beg),
        .v_end  (sh_v_end),
        .v2_beg (sh_v2_beg),
        .v2_end (sh_v2_end),
        .hs_w   (sh_hs_w),
        .vs_w   (sh_vs_w),
        .ctrl   (sh_ctrl),
        .hs     (hsync),
        .vs     (vsync),
        .act    (de)
    );

endmodule

// File: rtl/raster_gen_checker.sv
module raster_gen_checker
    import raster_gen_pkg::*;
#(
    parameter int HW = 12,
    parameter int VW = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic [HW-1:0]    h_pos,
    input logic [VW-1:0]    v_pos,
    input logic             field,
    input logic [HW-1:0]    sh_h_last,
    input logic [VW-1:0]    sh_v_last,
    input logic [VW-1:0]    sh_v2_total,
    input logic [CTL_W-1:0] sh_ctrl
);

    a_r2_h_step: assert property (@(posedge clk) disable iff (!rst_n)
        (h_pos != '0) |-> (h_pos == HW'($past(h_pos) + 1'b1)));

    a_r3_v_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (h_pos != '0) |-> $stable(v_pos));

    a_r3_v_bound: assert property (@(posedge clk) disable iff (!rst_n)
        !field |-> (v_pos <= sh_v_last));

    a_r7_bank_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        ((h_pos != '0) || (v_pos != '0)) |->
            ($stable(sh_h_last) && $stable(sh_v_last) && $stable(sh_ctrl)));

    a_r8_field_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (field != $past(field)) |-> ((h_pos == '0) && (v_pos == '0)));

    a_r9_field_needs_ilace: assert property (@(posedge clk) disable iff (!rst_n)
        field |-> (sh_ctrl[CTL_ILACE] && (sh_v2_total != '0)));

endmodule

bind raster_gen raster_gen_checker #(.HW(HW), .VW(VW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .h_pos       (h_pos),
    .v_pos       (v_pos),
    .field       (field),
    .sh_h_last   (sh_h_last),
    .sh_v_last   (sh_v_last),
    .sh_v2_total (sh_v2_total),
    .sh_ctrl     (sh_ctrl)
);

// File: tb/raster_gen_bench.sv
module raster_gen_bench;

    localparam int CLK_PERIOD = 10;
    localparam int HW = 12;
    localparam int VW = 11;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [HW-1:0] cfg_h_last, cfg_h_act_beg, cfg_h_act_end, cfg_hs_width;
    logic [VW-1:0] cfg_v_last, cfg_v_act_beg, cfg_v_act_end;
    logic [VW-1:0] cfg_v2_total, cfg_v2_act_beg, cfg_v2_act_end, cfg_vs_width;
    logic [2:0]    cfg_ctrl;
    logic          hsync, vsync, de, field;
    logic [HW-1:0] h_pos;
    logic [VW-1:0] v_pos;

    always #(CLK_PERIOD/2) clk = ~clk;

    raster_gen #(.HW(HW), .VW(VW)) u_raster_gen (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_h_last     (cfg_h_last),
        .cfg_v_last     (cfg_v_last),
        .cfg_h_act_beg  (cfg_h_act_beg),
        .cfg_h_act_end  (cfg_h_act_end),
        .cfg_v_act_beg  (cfg_v_act_beg),
        .cfg_v_act_end  (cfg_v_act_end),
        .cfg_v2_total   (cfg_v2_total),
        .cfg_v2_act_beg (cfg_v2_act_beg),
        .cfg_v2_act_end (cfg_v2_act_end),
        .cfg_hs_width   (cfg_hs_width),
        .cfg_vs_width   (cfg_vs_width),
        .cfg_ctrl       (cfg_ctrl),
        .hsync          (hsync),
        .vsync          (vsync),
        .de             (de),
        .field          (field),
        .h_pos          (h_pos),
        .v_pos          (v_pos)
    );

    int    checks = 0;
    int    errors = 0;
    string fld_tag = "R8";

    // Expected-state model built from the requirements.
    int m_h, m_v, m_f;
    int s_hl, s_vl, s_hb, s_he, s_vb, s_ve, s_v2t, s_v2b, s_v2e, s_hsw, s_vsw, s_ctl;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step();
        bit wrap_h;
        bit wrap_v;
        if (!rst_n) begin
            m_h = 0; m_v = 0; m_f = 0;
            s_hl = 0; s_vl = 0; s_hb = 0; s_he = 0; s_vb = 0; s_ve = 0;
            s_v2t = 0; s_v2b = 0; s_v2e = 0; s_hsw = 0; s_vsw = 0; s_ctl = 0;
        end else begin
            wrap_h = (m_h == s_hl);
            wrap_v = (m_f != 0) ? (m_v == s_v2t) : (m_v == s_vl);
            if (wrap_h) begin
                m_h = 0;
                if (wrap_v) begin
                    m_v   = 0;
                    m_f   = (cfg_ctrl[2] && cfg_v2_total != 0) ? (1 - m_f) : 0;
                    s_hl  = int'(cfg_h_last);    s_vl  = int'(cfg_v_last);
                    s_hb  = int'(cfg_h_act_beg); s_he  = int'(cfg_h_act_end);
                    s_vb  = int'(cfg_v_act_beg); s_ve  = int'(cfg_v_act_end);
                    s_v2t = int'(cfg_v2_total);  s_v2b = int'(cfg_v2_act_beg);
                    s_v2e = int'(cfg_v2_act_end);
                    s_hsw = int'(cfg_hs_width);  s_vsw = int'(cfg_vs_width);
                    s_ctl = int'(cfg_ctrl);
                end else begin
                    m_v = m_v + 1;
                end
            end else begin
                m_h = m_h + 1;
            end
        end
    endtask

    task automatic compare_all();
        int e_hs, e_vs, e_de, vb, ve;
        e_hs = ((m_h < s_hsw) ? 1 : 0) ^ (s_ctl & 1);
        e_vs = ((m_v < s_vsw) ? 1 : 0) ^ ((s_ctl >> 1) & 1);
        vb   = (m_f != 0) ? s_v2b : s_vb;
        ve   = (m_f != 0) ? s_v2e : s_ve;
        e_de = (m_h >= s_hb && m_h < s_he && m_v >= vb && m_v < ve) ? 1 : 0;
        chk("R2 h_pos", int'(h_pos), m_h);
        chk("R3 v_pos", int'(v_pos), m_v);
        chk("R4 hsync", int'(hsync), e_hs);
        chk("R5 vsync", int'(vsync), e_vs);
        chk("R6 de", int'(de), e_de);
        chk({fld_tag, " field"}, int'(field), m_f);
    endtask

    // Inputs are set before calling; the model predicts the next edge.
    task automatic tick();
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic rand_cfg();
        int hl, vl;
        hl = 8 + int'($urandom % 33);
        vl = 4 + int'($urandom % 17);
        cfg_h_last    = HW'(hl);
        cfg_v_last    = VW'(vl);
        cfg_h_act_beg = HW'($urandom % (hl + 2));
        cfg_h_act_end = HW'($urandom % (hl + 3));
        cfg_v_act_beg = VW'($urandom % (vl + 2));
        cfg_v_act_end = VW'($urandom % (vl + 3));
        cfg_hs_width  = HW'($urandom % 8);
        cfg_vs_width  = VW'($urandom % 5);
        cfg_ctrl      = 3'($urandom % 8);
        cfg_v2_total  = ($urandom % 4 == 0) ? '0 : VW'(vl + 1);
        cfg_v2_act_beg = VW'(($urandom % (vl + 2)));
        cfg_v2_act_end = VW'(($urandom % (vl + 3)));
    endtask

    task automatic set_cfg(input int hl, input int vl, input int hb, input int he,
                           input int vb, input int ve, input int v2t, input int v2b,
                           input int v2e, input int hsw, input int vsw, input int ctl);
        cfg_h_last = HW'(hl);  cfg_v_last = VW'(vl);
        cfg_h_act_beg = HW'(hb); cfg_h_act_end = HW'(he);
        cfg_v_act_beg = VW'(vb); cfg_v_act_end = VW'(ve);
        cfg_v2_total = VW'(v2t); cfg_v2_act_beg = VW'(v2b); cfg_v2_act_end = VW'(v2e);
        cfg_hs_width = HW'(hsw); cfg_vs_width = VW'(vsw);
        cfg_ctrl = 3'(ctl);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        set_cfg(19, 9, 4, 16, 1, 8, 0, 0, 0, 2, 1, 0);

        // R1: outputs held at zero during reset
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R1 hsync", int'(hsync), 0);
            chk("R1 vsync", int'(vsync), 0);
            chk("R1 de", int'(de), 0);
            chk("R1 field", int'(field), 0);
            chk("R1 h_pos", int'(h_pos), 0);
            chk("R1 v_pos", int'(v_pos), 0);
        end
        rst_n = 1'b1;
        tick();
        // R1: first edge out of reset captures the inputs; counters restart at 0
        chk("R1 h_pos after capture", int'(h_pos), 0);
        tick();
        chk("R1 h_pos counting", int'(h_pos), 1);

        // R7: mid-frame change is deferred to the field boundary
        for (int i = 0; i < 5000; i++) begin
            if (h_pos == 3 && v_pos == 2) break;
            tick();
        end
        cfg_h_last = HW'(5);
        for (int i = 0; i < 10; i++) tick();
        chk("R7 old line length kept", int'(h_pos), 13);
        for (int i = 0; i < 300; i++) tick();

        // R9: progressive with nonzero second-field inputs
        fld_tag = "R9";
        set_cfg(11, 6, 2, 10, 1, 5, 7, 0, 7, 3, 2, 3);
        for (int i = 0; i < 600; i++) tick();
        chk("R9 field stays low", int'(field), 0);
        fld_tag = "R8";

        // R8: interlace with one extra line in field 1
        set_cfg(13, 5, 0, 14, 1, 4, 6, 2, 5, 1, 1, 4);
        for (int i = 0; i < 800; i++) tick();

        // R6 R4 R5: minimum raster and saturated widths
        set_cfg(1, 0, 0, 2, 0, 1, 0, 0, 0, 9, 9, 0);
        for (int i = 0; i < 50; i++) tick();
        set_cfg(9, 3, 9, 10, 3, 4, 0, 0, 0, 0, 0, 3);
        for (int i = 0; i < 200; i++) tick();

        // Random configurations, sometimes rewritten mid-frame
        for (int r = 0; r < 40; r++) begin
            int n;
            rand_cfg();
            n = 300 + int'($urandom % 900);
            for (int k = 0; k < n; k++) begin
                if ($urandom % 200 == 0) rand_cfg();
                tick();
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule